// File: doc/BRIEF.md
# Serializer with Forwarded Clock Lane

This block turns a parallel word from the fabric into a serial bit stream on a fast serial-rate clock, one bit per clock cycle, most significant bit first. A free-running modulo-N word timer makes a load strobe once per word. The strobe copies the parallel input into a shift register, which then advances one bit per cycle. Consecutive words follow each other with no idle bit in between.

A second lane, built from the same load and shift logic, sends a source-synchronous forwarded clock. Its shift register is loaded with a constant bit pattern, so the clock keeps a fixed relation to the data. Three parameters are fixed at build time: the word width N (3 to 10), a clock divisor D (1, 2, 4, 6, 8 or 10) and edge or center alignment. With D of 2 or more, the forwarded clock has a period of D bit times and a 50 % duty cycle. With D equal to 1, the clock runs at word rate: one period per word. A combination that cannot repeat cleanly inside one word stops elaboration.

The word timer has two states. TS_PRIME runs from reset until the first load. TS_STREAM is steady streaming. The transition PRIME_TO_STREAM fires on the first load strobe. STREAM_HOLD keeps the timer in TS_STREAM. Reset returns the timer to TS_PRIME from either state.

Top module: `sertx_fwdclk`

## Requirements
- R1: On every clock edge where `rst` is high, the counter is cleared and both shift registers are cleared. As a result, `ser_data` and `ser_clk` are low in the cycle that follows.
- R2: The first load takes place on the N-th rising edge after the first edge on which `rst` is low. Both outputs stay low until that load.
- R3: A word goes out most significant bit first. Bit `par_data[N-1-k]` is on `ser_data` in the k-th cycle after its load edge, counting from 0.
- R4: `par_data` is sampled only on load edges. A load edge is every N-th edge after reset, which is when the internal counter has the value N-1. Values presented at any other time have no effect on `ser_data`.
- R5: Words are loaded every N cycles and follow each other back to back, with no idle or repeated bit.
- R6: With D of 2 or more, `ser_clk` is high for the first D/2 bits of every D-bit period and low for the next D/2 bits. The pattern restarts with each word, so a rising clock edge lines up with the first bit of a word (edge alignment).
- R7: With D equal to 1, `ser_clk` is high for the first ceil(N/2) bits of each word and low for the rest of the word.
- R8: With `CENTER_ALIGN` set to 1, the `ser_clk` pattern of R6 or R7 is inverted bit for bit.
- R9: `sertx_pkg::cfg_legal(n, d)` is true only when both of these hold: n is between 3 and 10, and d is 1, or d is one of 2, 4, 6, 8, 10 and divides n. An instance whose parameters fail this test does not elaborate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast serial-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| par_data | input | WORD_W | Parallel word, sampled on load edges |
| ser_data | output | 1 | Serial data bit, MSB first |
| ser_clk | output | 1 | Forwarded clock lane bit |

## Verification
The bench targets the following corner cases:
- **Reset release.** A timer that loads one cycle early or late shifts every word by one bit, and the first data check catches it.
- **Load sampling.** Random values sit on `par_data` in every cycle except the load cycle. A design that samples continuously, or one cycle off, sends those random values instead of the planned words.
- **Pattern period.** The clock lane is checked bit by bit for word-rate, data-rate and divided modes, each in both alignments. A wrong half-period or a missing inversion shows up as a mismatch in the first word.
- **Reset during streaming.** Reset is asserted in the middle of a word to show that the outputs drop low at once.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int MAX_W = 10;

    typedef enum logic [0:0] {
        TS_PRIME  = 1'b0,
        TS_STREAM = 1'b1
    } tx_state_e;

    function automatic bit cfg_legal(input int n, input int d);
        bit div_ok;
        div_ok = (d == 1) ||
                 ((d == 2 || d == 4 || d == 6 || d == 8 || d == 10) && (n % d == 0));
        return (n >= 3) && (n <= MAX_W) && div_ok;
    endfunction

    // Bit n-1 is the first bit sent in a word.
    function automatic logic [MAX_W-1:0] clk_pattern(input int n, input int d, input bit center);
        logic [MAX_W-1:0] pat;
        bit hi;
        int idx;
        pat = '0;
        for (int j = 0; j < MAX_W; j++) begin
            if (j < n) begin
                if (d == 1)
                    hi = (j < (n + 1) / 2);
                else if (d > 1)
                    hi = ((j % d) < (d / 2));
                else
                    hi = 1'b0;
                idx = n - 1 - j;
                if (idx >= 0 && idx < MAX_W)
                    pat[idx] = hi ^ center;
            end
        end
        return pat;
    endfunction

endpackage

// File: rtl/sertx_word_timer.sv
module sertx_word_timer #(
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst,
    output logic load_en,
    output logic shift_en
);
    import sertx_pkg::*;

    localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    tx_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          wrap;

    assign wrap = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TS_PRIME;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        cnt_d   = wrap ? '0 : cnt_q + 1'b1;
        state_d = state_q;
        unique case (state_q)
            TS_PRIME:  if (wrap) state_d = TS_STREAM;   // PRIME_TO_STREAM
            TS_STREAM: state_d = TS_STREAM;             // STREAM_HOLD
            default:   state_d = TS_PRIME;
        endcase
    end

    always_comb begin
        load_en  = wrap;
        shift_en = 1'b0;
        unique case (state_q)
            TS_PRIME:  shift_en = 1'b0;
            TS_STREAM: shift_en = 1'b1;
            default:   shift_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/sertx_shift_lane.sv
module sertx_shift_lane #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] par_in,
    output logic              ser_out
);
    logic [WORD_W-1:0] sreg_q;

    always_ff @(posedge clk) begin
        if (rst)
            sreg_q <= '0;
        else if (load_en)
            sreg_q <= par_in;
        else if (shift_en)
            sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
    end

    assign ser_out = sreg_q[WORD_W-1];

endmodule

// File: rtl/sertx_fwdclk.sv
module sertx_fwdclk #(
    parameter int WORD_W       = 8,
    parameter int CLK_DIV      = 2,
    parameter int CENTER_ALIGN = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] par_data,
    output logic              ser_data,
    output logic              ser_clk
);
    import sertx_pkg::*;

    localparam int NUM_LANES = 2;
    localparam logic [MAX_W-1:0] CLK_FULL = clk_pattern(WORD_W, CLK_DIV, CENTER_ALIGN != 0);
    localparam logic [WORD_W-1:0] CLK_WORD = CLK_FULL[WORD_W-1:0];

    generate
        if (!cfg_legal(WORD_W, CLK_DIV)) begin : g_bad_cfg
            $error("sertx_fwdclk: word width and clock divisor do not form a legal pair");
        end
    endgenerate

    logic              load_en;
    logic              shift_en;
    logic [WORD_W-1:0] lane_word [NUM_LANES];
    logic              lane_bit  [NUM_LANES];

    sertx_word_timer #(.WORD_W(WORD_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .shift_en (shift_en)
    );

    assign lane_word[0] = par_data;
    assign lane_word[1] = CLK_WORD;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        sertx_shift_lane #(.WORD_W(WORD_W)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .load_en  (load_en),
            .shift_en (shift_en),
            .par_in   (lane_word[g]),
            .ser_out  (lane_bit[g])
        );
    end

    assign ser_data = lane_bit[0];
    assign ser_clk  = lane_bit[1];

endmodule

// File: rtl/sertx_fwdclk_chk.sv
module sertx_fwdclk_chk #(
    parameter int WORD_W       = 8,
    parameter int CLK_DIV      = 2,
    parameter int CENTER_ALIGN = 0
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] par_data,
    input logic              ser_data,
    input logic              ser_clk,
    input logic              load_en
);
    import sertx_pkg::*;

    localparam logic [MAX_W-1:0] PAT = clk_pattern(WORD_W, CLK_DIV, CENTER_ALIGN != 0);

    logic [7:0] since_load;
    logic       have_word;
    logic       exp_clk;
    int         idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_load <= '0;
            have_word  <= 1'b0;
        end else if (load_en) begin
            since_load <= '0;
            have_word  <= 1'b1;
        end else begin
            since_load <= since_load + 8'd1;
        end
    end

    always_comb begin
        idx     = WORD_W - 1 - int'(since_load);
        exp_clk = (idx >= 0 && idx < MAX_W) ? PAT[idx] : 1'b0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!ser_data && !ser_clk)); // R1
    AST_IDLE_UNTIL_LOAD: assert property (@(posedge clk) disable iff (rst)
        !have_word |-> (!ser_data && !ser_clk)); // R2
    AST_LOAD_SPACING: assert property (@(posedge clk) disable iff (rst)
        load_en |-> (since_load == 8'(WORD_W - 1))); // R5
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        since_load < 8'(WORD_W)); // R5
    AST_MSB_LEADS: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (ser_data == $past(par_data[WORD_W-1]))); // R3
    AST_CLK_PATTERN: assert property (@(posedge clk) disable iff (rst)
        have_word |-> (ser_clk == exp_clk)); // R6

endmodule

bind sertx_fwdclk sertx_fwdclk_chk #(
    .WORD_W       (WORD_W),
    .CLK_DIV      (CLK_DIV),
    .CENTER_ALIGN (CENTER_ALIGN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .par_data (par_data),
    .ser_data (ser_data),
    .ser_clk  (ser_clk),
    .load_en  (load_en)
);

// File: tb/sertx_fwdclk_test.sv
`timescale 1ns/1ps
module sertx_fwdclk_test;

    localparam int NCFG  = 21;
    localparam int NWORD = 8;
    localparam int CFG_N [NCFG] = '{3,4,4,4,5,6,6,6,7,8,8,8,8,9,10,10,10, 8,6,5,10};
    localparam int CFG_D [NCFG] = '{1,1,2,4,1,1,2,6,1,1,2,4,8,1,1,2,10, 4,6,1,2};
    localparam int CFG_C [NCFG] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0, 1,1,1,1};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int checks   = 0;
    int errors   = 0;
    int done_cnt = 0;

    task automatic check(input bit ok, input string req, input int cfg,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cfg=%0d actual=%0d expected=%0d at %0t", req, cfg, act, exp, $time);
        end
    endtask

    function automatic bit bench_clk_bit(input int n, input int d, input int c, input int j);
        bit hi;
        if (d == 1) hi = (j < (n + 1) / 2);
        else        hi = ((j % d) < (d / 2));
        return hi ^ (c != 0);
    endfunction

    function automatic bit bench_legal(input int n, input int d);
        bit dv;
        dv = (d == 1) || ((d == 2 || d == 4 || d == 6 || d == 8 || d == 10) && (n % d == 0));
        return (n >= 3) && (n <= 10) && dv;
    endfunction

    for (genvar gi = 0; gi < NCFG; gi++) begin : g_cfg
        localparam int N = CFG_N[gi];
        localparam int D = CFG_D[gi];
        localparam int C = CFG_C[gi];

        logic         rst_l;
        logic [N-1:0] din;
        logic         sd;
        logic         sc;

        sertx_fwdclk #(.WORD_W(N), .CLK_DIV(D), .CENTER_ALIGN(C)) uut (
            .clk      (clk),
            .rst      (rst_l),
            .par_data (din),
            .ser_data (sd),
            .ser_clk  (sc)
        );

        initial begin
            logic [9:0] words [NWORD];
            string ctag;
            rst_l = 1'b1;
            din   = '0;
            ctag  = (D == 1) ? ((C != 0) ? "R7 R8" : "R7") : ((C != 0) ? "R6 R8" : "R6");
            #1;
            for (int k = 0; k < NWORD; k++) begin
                case (k)
                    0: words[k] = 10'h3FF;
                    1: words[k] = 10'h000;
                    2: words[k] = 10'h2AA;
                    3: words[k] = 10'(1 << (N - 1));
                    default: words[k] = 10'($urandom);
                endcase
            end
            repeat (3) @(negedge clk);
            check(sd == 1'b0 && sc == 1'b0, "R1", gi, {sd, sc}, 0);
            rst_l = 1'b0;
            din   = N'($urandom);
            for (int e = 1; e <= (NWORD + 1) * N - 1; e++) begin
                @(negedge clk);
                if (e < N) begin
                    check(sd == 1'b0 && sc == 1'b0, "R2", gi, {sd, sc}, 0);
                end else begin
                    int  k;
                    int  j;
                    bit  ed;
                    bit  ec;
                    k  = e / N - 1;
                    j  = e % N;
                    ed = words[k][N-1-j];
                    ec = bench_clk_bit(N, D, C, j);
                    check(sd == ed, "R3 R4 R5", gi, sd, ed);
                    check(sc == ec, ctag, gi, sc, ec);
                end
                if (((e + 1) % N == 0) && ((e + 1) / N - 1 < NWORD))
                    din = words[(e + 1) / N - 1][N-1:0];
                else
                    din = N'($urandom);
            end
            // reset in the middle of a word
            repeat (N / 2) @(negedge clk);
            rst_l = 1'b1;
            @(negedge clk);
            check(sd == 1'b0 && sc == 1'b0, "R1", gi, {sd, sc}, 0);
            done_cnt++;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        for (int n = 0; n <= 12; n++) begin
            for (int d = 0; d <= 12; d++) begin
                bit exp_ok;
                bit act_ok;
                exp_ok = bench_legal(n, d);
                act_ok = sertx_pkg::cfg_legal(n, d);
                check(act_ok == exp_ok, "R9", n * 100 + d, act_ok, exp_ok);
            end
        end
        wait (done_cnt == NCFG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", done_cnt, NCFG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule